// File: doc/BRIEF.md
# Directional Dial Combination Lock

This block is the decision core of a dial-style combination lock. Each time the dial settles, an upstream stage presents one entry for a single clock cycle. An entry is a turn direction (right or left) together with a 6-bit dial number. The lock opens only when three specific entries arrive one after another in a fixed order. The same numbers given in another order, or with the wrong direction, do not open it. The default combination is right to 13, then left to 22, then right to 3. The combination is set by parameters at build time.

Progress through the combination is kept in a four-state machine held in two flip-flops:

| Code | Meaning |
|------|---------|
| 00 | locked, no progress |
| 01 | locked, first entry matched |
| 10 | locked, first two entries matched |
| 11 | open |

The single output is registered state decoded to an open flag. A wrong entry discards progress. An entry equal to the first element of the combination is always taken as a fresh start. Once open, the lock stays open until the next valid entry or a reset.

Top module: `combolock_fsm`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the lock returns to the no-progress state. `unlocked` is 0 after that edge, and any earlier partial progress is lost.
- R2: On a rising edge where `entry_vld` is 0, the state does not change, whatever `entry_dir` and `entry_val` carry.
- R3: The three valid entries right-13, left-22, right-3, given in that order from the no-progress state, set `unlocked` to 1 after the edge that samples the third entry. Right is `entry_dir`=1 and left is `entry_dir`=0.
- R4: `unlocked` depends only on the stored state. It rises only after a clock edge that sampled a valid entry, and it never follows the dial inputs between edges.
- R5: In any locked state, a valid entry that is neither the next expected entry nor the first element returns the lock to the no-progress state.
- R6: In any locked state, a valid entry equal to the first element (right-13) moves the lock to the first-matched state. For example, right-13, right-13, left-22, right-3 opens it.
- R7: In the open state, any valid entry locks it again and returns it to the no-progress state. This holds even when the entry is right-13, so a following left-22, right-3 does not reopen it.
- R8: The direction is part of every entry. A correct number given with the wrong direction counts as a wrong entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| entry_vld | input | 1 | High for one cycle per dial entry |
| entry_dir | input | 1 | Turn direction of the entry: 1 = right, 0 = left |
| entry_val | input | 6 | Dial number of the entry |
| unlocked | output | 1 | 1 while the lock is open |

## Verification
The hardest case to reach from the ports is the open state followed by an entry equal to the first element. The design must treat that entry as a relock to the no-progress state, not as a fresh start. To reach it, the bench first walks a complete correct sequence. It then applies right-13 and the rest of the combination, and `unlocked` must stay low. Reset asserted in the middle of a sequence and correct numbers with the wrong direction are also driven directly. After that, a long random run draws its values mostly from the combination, so that repeated first entries and half-finished sequences occur often. Each cycle is compared against a behavioural model.

// File: rtl/combolock_pkg.sv
// Package: shared types for the dial combination lock.
// Assumes: two state bits suffice for the four progress states.
package combolock_pkg;

    // Progress through the combination; codes are fixed by the design.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_OPEN = 2'b11
    } lock_state_e;

    // Number of entries in the combination.
    localparam int unsigned STEP_COUNT = 3;

    // Direction encoding of an entry.
    localparam logic DIR_LEFT  = 1'b0;
    localparam logic DIR_RIGHT = 1'b1;

endpackage

// File: rtl/lock_step_match.sv
// Module: lock_step_match
// Compares the current dial entry with every element of the combination
// and raises one hit bit per element. Purely combinational.
// Assumes: element i occupies bits [i*VAL_W +: VAL_W] of STEP_VALS and bit i
// of STEP_DIRS.
module lock_step_match #(
    parameter int unsigned VAL_W = 6,
    parameter int unsigned STEPS = 3,
    parameter logic [STEPS-1:0]       STEP_DIRS = '0,
    parameter logic [STEPS*VAL_W-1:0] STEP_VALS = '0
) (
    input  logic             entry_dir,
    input  logic [VAL_W-1:0] entry_val,
    output logic [STEPS-1:0] step_hit
);

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        // Direction and number must both agree for a hit.
        always_comb begin
            step_hit[i] = (entry_dir == STEP_DIRS[i]) &&
                          (entry_val == STEP_VALS[i*VAL_W +: VAL_W]);
        end
    end

endmodule

// File: rtl/lock_next_state.sv
// Module: lock_next_state
// Next-state logic of the lock. Only a valid entry moves the state.
// Assumes: step_hit[0..2] are the hits for the first, second and third
// elements of the combination.
module lock_next_state
    import combolock_pkg::*;
(
    input  lock_state_e cur_state,
    input  logic        entry_vld,
    input  logic [2:0]  step_hit,
    output lock_state_e nxt_state
);

    // Choose the next state from the present state and the entry hits.
    always_comb begin
        nxt_state = cur_state;
        if (entry_vld) begin
            unique case (cur_state)
                ST_IDLE: nxt_state = step_hit[0] ? ST_ONE : ST_IDLE;
                ST_ONE:  nxt_state = step_hit[1] ? ST_TWO :
                                     (step_hit[0] ? ST_ONE : ST_IDLE);
                ST_TWO:  nxt_state = step_hit[2] ? ST_OPEN :
                                     (step_hit[0] ? ST_ONE : ST_IDLE);
                ST_OPEN: nxt_state = ST_IDLE;
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lock_state_reg.sv
// Module: lock_state_reg
// The two state flip-flops of the lock.
// Assumes: rst_n is synchronous and active low.
module lock_state_reg
    import combolock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  lock_state_e nxt_state,
    output lock_state_e cur_state
);

    // Register the next state; reset clears all progress.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= ST_IDLE;
        else        cur_state <= nxt_state;
    end

endmodule

// File: rtl/combolock_fsm.sv
// Module: combolock_fsm (top)
// Sequential dial lock. It opens after three direction/number entries
// arrive in the configured order and decodes the open flag from the state.
// Assumes: one entry per entry_vld pulse, with inputs stable around the edge.
module combolock_fsm
    import combolock_pkg::*;
#(
    parameter int unsigned VAL_W = 6,
    parameter logic        DIR1  = DIR_RIGHT,
    parameter int unsigned VAL1  = 13,
    parameter logic        DIR2  = DIR_LEFT,
    parameter int unsigned VAL2  = 22,
    parameter logic        DIR3  = DIR_RIGHT,
    parameter int unsigned VAL3  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_vld,
    input  logic             entry_dir,
    input  logic [VAL_W-1:0] entry_val,
    output logic             unlocked
);

    localparam logic [VAL_W-1:0] V1 = VAL1[VAL_W-1:0];
    localparam logic [VAL_W-1:0] V2 = VAL2[VAL_W-1:0];
    localparam logic [VAL_W-1:0] V3 = VAL3[VAL_W-1:0];
    localparam logic [STEP_COUNT-1:0]       STEP_DIRS = {DIR3, DIR2, DIR1};
    localparam logic [STEP_COUNT*VAL_W-1:0] STEP_VALS = {V3, V2, V1};

    logic [STEP_COUNT-1:0] step_hit;
    lock_state_e           cur_state;
    lock_state_e           nxt_state;

    lock_step_match #(
        .VAL_W     (VAL_W),
        .STEPS     (STEP_COUNT),
        .STEP_DIRS (STEP_DIRS),
        .STEP_VALS (STEP_VALS)
    ) u_match (
        .entry_dir (entry_dir),
        .entry_val (entry_val),
        .step_hit  (step_hit)
    );

    lock_next_state u_next (
        .cur_state (cur_state),
        .entry_vld (entry_vld),
        .step_hit  (step_hit),
        .nxt_state (nxt_state)
    );

    lock_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    // Open flag decoded from the stored state only.
    always_comb begin
        unlocked = (cur_state == ST_OPEN);
    end

endmodule

// File: rtl/combolock_fsm_chk.sv
// Module: combolock_fsm_chk
// Property checker bound to combolock_fsm. It computes entry matches on
// its own from the combination parameters.
module combolock_fsm_chk #(
    parameter int unsigned VAL_W = 6,
    parameter logic        DIR1  = 1'b1,
    parameter int unsigned VAL1  = 13,
    parameter logic        DIR2  = 1'b0,
    parameter int unsigned VAL2  = 22,
    parameter logic        DIR3  = 1'b1,
    parameter int unsigned VAL3  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             entry_vld,
    input logic             entry_dir,
    input logic [VAL_W-1:0] entry_val,
    input logic             unlocked,
    input logic [1:0]       state
);

    logic is_first, is_second, is_third, rst_was_low;

    // Independent match decode of the present entry.
    always_comb begin
        is_first  = (entry_dir == DIR1) && (entry_val == VAL1[VAL_W-1:0]);
        is_second = (entry_dir == DIR2) && (entry_val == VAL2[VAL_W-1:0]);
        is_third  = (entry_dir == DIR3) && (entry_val == VAL3[VAL_W-1:0]);
    end

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    a_r1_reset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        rst_was_low |-> (state == 2'b00 && !unlocked));

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_vld |=> $stable(state));

    a_r3_third_entry_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && state == 2'b10 && is_third) |=> unlocked);

    a_r4_open_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(entry_vld));

    a_r5_wrong_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && state != 2'b11 && !is_first &&
         !(state == 2'b01 && is_second) && !(state == 2'b10 && is_third))
        |=> (state == 2'b00));

    a_r6_first_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && state != 2'b11 && is_first) |=> (state == 2'b01));

    a_r7_entry_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_vld && unlocked) |=> (!unlocked && state == 2'b00));

endmodule

bind combolock_fsm combolock_fsm_chk #(
    .VAL_W (VAL_W), .DIR1 (DIR1), .VAL1 (VAL1), .DIR2 (DIR2),
    .VAL2 (VAL2), .DIR3 (DIR3), .VAL3 (VAL3)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_vld (entry_vld),
    .entry_dir (entry_dir),
    .entry_val (entry_val),
    .unlocked  (unlocked),
    .state     (cur_state)
);

// File: tb/tb_combolock_fsm.sv
`timescale 1ns/1ps
module tb_combolock_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       entry_vld = 1'b0;
    logic       entry_dir = 1'b0;
    logic [5:0] entry_val = '0;
    logic       unlocked;

    int total = 0;
    int bad   = 0;
    int model = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    combolock_fsm dut (
        .clk(clk), .rst_n(rst_n), .entry_vld(entry_vld),
        .entry_dir(entry_dir), .entry_val(entry_val), .unlocked(unlocked)
    );

    function automatic bit hit(input bit d, input int v, input bit ed, input int ev);
        return (d == ed) && (v == ev);
    endfunction

    // Behavioural reference: progress 0..3, 3 means open.
    task automatic model_step();
        bit f1, f2, f3;
        f1 = hit(entry_dir, entry_val, 1'b1, 13);
        f2 = hit(entry_dir, entry_val, 1'b0, 22);
        f3 = hit(entry_dir, entry_val, 1'b1, 3);
        if (!rst_n) model = 0;
        else if (entry_vld) begin
            if (model == 3)                model = 0;
            else if (model == 1 && f2)     model = 2;
            else if (model == 2 && f3)     model = 3;
            else if (f1)                   model = 1;
            else                           model = 0;
        end
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge.
    task automatic cyc(input bit rn, input bit v, input bit d, input int n, input string tag);
        bit exp;
        rst_n = rn; entry_vld = v; entry_dir = d; entry_val = n[5:0];
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp = (model == 3);
        total++;
        if (unlocked !== exp) begin
            bad++;
            $display("FAIL %s: unlocked=%0b expected=%0b", tag, unlocked, exp);
        end
    endtask

    task automatic ent(input bit d, input int n, input string tag);
        cyc(1'b1, 1'b1, d, n, tag);
    endtask

    initial begin
        @(negedge clk);
        cyc(1'b0, 1'b0, 1'b0, 0, "R1 reset");
        cyc(1'b0, 1'b1, 1'b1, 13, "R1 reset ignores entry");
        // R3: correct sequence opens.
        ent(1'b1, 13, "R3 first"); ent(1'b0, 22, "R3 second"); ent(1'b1, 3, "R3 opens");
        // R2/R4: non-valid cycles hold the open state.
        cyc(1'b1, 1'b0, 1'b1, 13, "R2 hold open");
        cyc(1'b1, 1'b0, 1'b0, 55, "R4 inputs without strobe");
        // R7: a valid entry relocks, even the first element.
        ent(1'b1, 13, "R7 relock on first element");
        ent(1'b0, 22, "R7 no resume"); ent(1'b1, 3, "R7 stays locked");
        // R2: gaps between entries, garbage while strobe low.
        ent(1'b1, 13, "R2 first");
        cyc(1'b1, 1'b0, 1'b1, 3, "R2 gap"); cyc(1'b1, 1'b0, 1'b0, 9, "R2 gap");
        ent(1'b0, 22, "R2 second");
        cyc(1'b1, 1'b0, 1'b1, 40, "R2 gap");
        ent(1'b1, 3, "R2 opens after gaps");
        ent(1'b0, 0, "R7 any entry relocks");
        // R6: repeated first element restarts.
        ent(1'b1, 13, "R6 a"); ent(1'b1, 13, "R6 b");
        ent(1'b0, 22, "R6 c"); ent(1'b1, 3, "R6 opens");
        ent(1'b1, 3, "R7 relock");
        // R6: first element in state C restarts.
        ent(1'b1, 13, "R6"); ent(1'b0, 22, "R6"); ent(1'b1, 13, "R6 restart from C");
        ent(1'b0, 22, "R6"); ent(1'b1, 3, "R6 opens after restart");
        ent(1'b1, 1, "R7 relock");
        // R5: wrong entry in B and C.
        ent(1'b1, 13, "R5"); ent(1'b0, 21, "R5 wrong in B");
        ent(1'b0, 22, "R5 stale second"); ent(1'b1, 3, "R5 not open");
        ent(1'b1, 13, "R5"); ent(1'b0, 22, "R5"); ent(1'b1, 4, "R5 wrong in C");
        ent(1'b1, 3, "R5 third alone not open");
        // R8: wrong direction.
        ent(1'b0, 13, "R8 left 13"); ent(1'b0, 22, "R8"); ent(1'b1, 3, "R8 not open");
        ent(1'b1, 13, "R8"); ent(1'b1, 22, "R8 right 22"); ent(1'b1, 3, "R8 not open");
        ent(1'b1, 13, "R8"); ent(1'b0, 22, "R8"); ent(1'b0, 3, "R8 left 3 not open");
        // R1: reset mid-sequence loses progress.
        ent(1'b1, 13, "R1"); ent(1'b0, 22, "R1");
        cyc(1'b0, 1'b0, 1'b0, 0, "R1 reset in C");
        ent(1'b1, 3, "R1 progress lost");
        // R1: reset while open.
        ent(1'b1, 13, "R1"); ent(1'b0, 22, "R1"); ent(1'b1, 3, "R1 open");
        cyc(1'b0, 1'b0, 1'b0, 0, "R1 reset closes");
        // R5: random run biased to combination values.
        for (int i = 0; i < 3000; i++) begin
            int pick, n;
            bit d, v, rn;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1: n = 13;
                2, 3: n = 22;
                4, 5: n = 3;
                default: n = $urandom_range(0, 63);
            endcase
            d  = (pick < 6 && $urandom_range(0, 4) != 0) ? (n != 22) : 1'($urandom_range(0, 1));
            v  = ($urandom_range(0, 3) != 0);
            rn = ($urandom_range(0, 199) != 0);
            cyc(rn, v, d, n, "R5 random");
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: unlocked=%0b expected=finish", unlocked);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule